// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block sets the bit timing of an I2C master. A power-of-two prescaler divides the functional clock into ticks. A phase engine counts those ticks through alternating SCL-high and SCL-low phases and drives the SCL output level. On the same ticks it raises single-cycle strobes: SCL rising, SCL falling, the point where the START/STOP setup and hold time has elapsed, and the point after SCL falls where SDA may be changed. The byte-level controller consumes these strobes. Pad drivers and input filtering sit outside the block.

Software programs the block through a small write port. A control word carries the prescale exponent, the timing-bank select, the enable and a self-clearing soft reset. Two timing words hold the phase counts, one for normal operation and one for high-speed operation. Each timing word packs four 6-bit counts. A slave can stretch the clock: while the engine is in the high phase and the sampled SCL input reads low, the high phase does not advance. The `scl_in` input is taken to be already synchronised.

Top module: `sclk_timing_gen`

## Requirements
- R1: After reset `scl_o` is 1, every strobe is 0, the block is disabled and all timing counts are zero.
- R2: A write (`cfg_we`=1) takes effect from the next cycle. `cfg_addr` selects the target: 0 is control, 1 is timing bank 0, 2 is timing bank 1. Control bits: [2:0] prescale exponent P, [3] bank select, [4] enable, [5] soft reset. In a timing word, [5:0] is the low count LO, [13:8] the high count HI, [21:16] the hold count SH and [29:24] the data-valid count DV. All other timing-word bits are ignored.
- R3: While enabled, one tick occurs every 2^P clock cycles. The first tick falls 2^P cycles after the cycle in which the enabling write is presented. The strobes occur only in tick cycles.
- R4: The low phase lasts LO+1 ticks. One full SCL period lasts HI+LO+3+FILT/2 ticks, where FILT is the filter parameter, so the high phase takes the remainder. Enabling starts the engine at the beginning of a high phase.
- R5: `scl_fall_stb` is high in the last tick of a high phase and `scl_rise_stb` in the last tick of a low phase. `scl_o` takes its new level in the following cycle.
- R6: `sda_chg_stb` is high in the (DV+1)-th tick of each low phase. It never fires when DV+1 exceeds the low-phase length.
- R7: `sethold_stb` is high in the (SH+1)-th counted tick of each high phase. It never fires when SH+1 exceeds the high-phase length.
- R8: The counts come from bank 1 when control bit 3 is set and from bank 0 otherwise.
- R9: A tick in a high phase with `scl_in` low is not counted and raises no strobe. `scl_o` stays 1 while it lasts.
- R10: While disabled, no strobe fires, `scl_o` is 1 and the counters are reloaded. A later enable restarts the sequence from the top.
- R11: A control write with bit 5 set suppresses every strobe in the next cycle and reloads the counters. Ticks then restart as if enabling had happened in that cycle. Bit 5 is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration target select |
| cfg_wdata | input | 32 | Configuration write data |
| scl_in | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | SCL level requested by the engine |
| scl_rise_stb | output | 1 | Low phase ends this tick |
| scl_fall_stb | output | 1 | High phase ends this tick |
| sethold_stb | output | 1 | START/STOP setup-hold time elapsed |
| sda_chg_stb | output | 1 | SDA may change now |

## Verification
The bench builds the block with the default prescale width of 3 and a filter setting of 2, which puts 4 overhead ticks into every period. Most scenarios run with exponent 0, so every cycle is a tick. That keeps the phases a handful of cycles long and lets a strobe that shares a tick with a phase end, and a stretch of an exact number of ticks, be placed cycle by cycle. One scenario uses exponent 2 to show the tick spacing. Counts at the edges (zero, equal to the last tick of a phase, and beyond the phase) are chosen so that coincident strobes and strobes that never fire both appear.

// File: rtl/sclk_tgen_pkg.sv
package sclk_tgen_pkg;
  localparam int FLD_W   = 6;
  localparam int CNT_W   = FLD_W + 2;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int NBANK   = 2;

  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = 8;
  localparam int SH_LSB  = 16;
  localparam int DV_LSB  = 24;

  localparam int C_HS_BIT   = 3;
  localparam int C_EN_BIT   = 4;
  localparam int C_SRST_BIT = 5;

  localparam int A_CTRL  = 0;
  localparam int A_BANK0 = 1;

  typedef struct packed {
    logic [FLD_W-1:0] datavd;
    logic [FLD_W-1:0] sethold;
    logic [FLD_W-1:0] clkhi;
    logic [FLD_W-1:0] clklo;
  } tgen_timing_t;

  function automatic tgen_timing_t unpack_timing(logic [WORD_W-1:0] w);
    tgen_timing_t r;
    r.datavd  = w[DV_LSB +: FLD_W];
    r.sethold = w[SH_LSB +: FLD_W];
    r.clkhi   = w[HI_LSB +: FLD_W];
    r.clklo   = w[LO_LSB +: FLD_W];
    return r;
  endfunction

  // high phase carries the fixed overhead and half the filter delay
  function automatic logic [CNT_W-1:0] high_ticks(logic [FLD_W-1:0] hi, int filt);
    return CNT_W'(hi) + CNT_W'(2 + filt / 2);
  endfunction

  function automatic logic [CNT_W-1:0] low_ticks(logic [FLD_W-1:0] lo);
    return CNT_W'(lo) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/sclk_tgen_regs.sv
module sclk_tgen_regs
  import sclk_tgen_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [PRE_W-1:0]    pre,
  output logic                hs_sel,
  output logic                run,
  output logic                srst,
  output tgen_timing_t        bank [NBANK]
);
  logic ctrl_hit;
  assign ctrl_hit = cfg_we && (cfg_addr == ADDR_W'(A_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      hs_sel <= 1'b0;
      run    <= 1'b0;
      srst   <= 1'b0;
    end else begin
      srst <= ctrl_hit && cfg_wdata[C_SRST_BIT];
      if (ctrl_hit) begin
        pre    <= cfg_wdata[PRE_W-1:0];
        hs_sel <= cfg_wdata[C_HS_BIT];
        run    <= cfg_wdata[C_EN_BIT];
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank[b] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(A_BANK0 + b))
        bank[b] <= unpack_timing(cfg_wdata);
    end
  end
endmodule

// File: rtl/sclk_tgen_presc.sv
module sclk_tgen_presc #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             srst,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  function automatic logic [DIV_W-1:0] div_limit(logic [PRE_W-1:0] p);
    return DIV_W'((64'd1 << p) - 64'd1);
  endfunction

  logic [DIV_W-1:0] div_q;

  assign tick = run && !srst && (div_q >= div_limit(pre));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (!run || srst || tick) div_q <= '0;
    else div_q <= div_q + DIV_W'(1);
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre != '0) |=> (!tick || pre == '0));
endmodule

// File: rtl/sclk_tgen_phase.sv
module sclk_tgen_phase
  import sclk_tgen_pkg::*;
#(
  parameter int FILT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         srst,
  input  logic         tick,
  input  logic         scl_in,
  input  tgen_timing_t tim,
  output logic         scl_o,
  output logic         rise_stb,
  output logic         fall_stb,
  output logic         sethold_stb,
  output logic         sda_stb
);
  logic             hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stall, adv, hi_last, lo_last;

  assign stall   = hi_q && !scl_in;
  assign adv     = run && !srst && tick && !stall;
  assign hi_last = hi_q && (cnt_q >= high_ticks(tim.clkhi, FILT) - CNT_W'(1));
  assign lo_last = !hi_q && (cnt_q >= low_ticks(tim.clklo) - CNT_W'(1));

  assign fall_stb    = adv && hi_last;
  assign rise_stb    = adv && lo_last;
  assign sethold_stb = adv && hi_q && (cnt_q == CNT_W'(tim.sethold));
  assign sda_stb     = adv && !hi_q && (cnt_q == CNT_W'(tim.datavd));
  assign scl_o       = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b1;
      cnt_q <= '0;
    end else if (!run || srst) begin
      hi_q  <= 1'b1;
      cnt_q <= '0;
    end else if (adv) begin
      if (fall_stb || rise_stb) begin
        hi_q  <= !hi_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R5
  fall_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !scl_o);
  // R5
  rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> scl_o);
  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !srst && scl_o && !scl_in) |=> scl_o);
  // R6
  sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_stb |-> !scl_o);
  // R7
  sethold_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sethold_stb |-> scl_o);
endmodule

// File: rtl/sclk_timing_gen.sv
module sclk_timing_gen
  import sclk_tgen_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int FILT  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        scl_in,
  output logic        scl_o,
  output logic        scl_rise_stb,
  output logic        scl_fall_stb,
  output logic        sethold_stb,
  output logic        sda_chg_stb
);
  logic [PRE_W-1:0] pre;
  logic             hs_sel, run, srst, tick;
  tgen_timing_t     bank [NBANK];
  tgen_timing_t     tim_act;

  sclk_tgen_regs #(.PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pre(pre), .hs_sel(hs_sel), .run(run),
    .srst(srst), .bank(bank)
  );

  sclk_tgen_presc #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .srst(srst), .pre(pre), .tick(tick)
  );

  assign tim_act = bank[hs_sel];

  sclk_tgen_phase #(.FILT(FILT)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .srst(srst), .tick(tick),
    .scl_in(scl_in), .tim(tim_act), .scl_o(scl_o),
    .rise_stb(scl_rise_stb), .fall_stb(scl_fall_stb),
    .sethold_stb(sethold_stb), .sda_stb(sda_chg_stb)
  );

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(scl_rise_stb || scl_fall_stb || sethold_stb || sda_chg_stb));
  // R11
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> !(scl_rise_stb || scl_fall_stb || sethold_stb || sda_chg_stb));
endmodule

// File: tb/tb_sclk_timing_gen.sv
`timescale 1ns/100ps
module tb_sclk_timing_gen;
  localparam int FILT = 2;
  localparam int K_SH = 0, K_FALL = 1, K_SDA = 2, K_RISE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic hold_low = 1'b0;
  logic scl_in, scl_o, rise, fall, sh, sda;

  always #2.5 clk = ~clk;
  assign scl_in = scl_o & ~hold_low;

  sclk_timing_gen #(.PRE_W(3), .FILT(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .scl_in(scl_in), .scl_o(scl_o),
    .scl_rise_stb(rise), .scl_fall_stb(fall), .sethold_stb(sh),
    .sda_chg_stb(sda)
  );

  typedef struct { int c; int k; } ev_t;
  ev_t expq[$];
  int cyc = 0;
  int errors = 0;
  int checks = 0;
  string tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string kreq(int k);
    if (k == K_SH) return "R7";
    if (k == K_SDA) return "R6";
    return "R5";
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic take(int k);
    ev_t e;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL %s/R10 unexpected strobe kind %0d at cycle %0d: actual 1 expected 0",
               tag, k, cyc);
    end else begin
      e = expq.pop_front();
      if (e.c != cyc || e.k != k) begin
        errors++;
        $display("FAIL %s/%s strobe: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 tag, kreq(e.k), k, cyc, e.k, e.c);
      end
    end
  endtask

  // monitor: fixed order within a cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (sh) take(K_SH);
      if (fall) take(K_FALL);
      if (sda) take(K_SDA);
      if (rise) take(K_RISE);
    end
  end

  function automatic logic [31:0] ctrl_word(int p, bit hs, bit en, bit sr);
    return 32'(p) | (32'(hs) << 3) | (32'(en) << 4) | (32'(sr) << 5);
  endfunction

  function automatic logic [31:0] tword(int dv, int shc, int hi, int lo, bit junk);
    logic [31:0] w;
    w = (32'(dv) << 24) | (32'(shc) << 16) | (32'(hi) << 8) | 32'(lo);
    if (junk) w = w | 32'hC0C0_C0C0;
    return w;
  endfunction

  task automatic push(int c, int k);
    ev_t e;
    e.c = c;
    e.k = k;
    expq.push_back(e);
  endtask

  // expected strobe cycles from R3..R9
  task automatic push_periods(int w, int p, int lo, int hi, int shc, int dv,
                              int nper, int sp, int m, output int last);
    int l, per, h, t0;
    l = lo + 1;
    per = hi + lo + 3 + FILT / 2;
    h = per - l;
    t0 = 0;
    for (int j = 0; j < nper; j++) begin
      int ext, hj;
      ext = (j == sp) ? m : 0;
      hj = h + ext;
      if (shc + 1 <= h) push(w + ((t0 + ext + shc + 1) << p), K_SH);
      push(w + ((t0 + hj) << p), K_FALL);
      if (dv + 1 <= l) push(w + ((t0 + hj + dv + 1) << p), K_SDA);
      push(w + ((t0 + hj + l) << p), K_RISE);
      t0 += hj + l;
    end
    last = w + (t0 << p);
  endtask

  task automatic wr_now(int a, logic [31:0] d);
    cfg_we = 1'b1;
    cfg_addr = 2'(a);
    cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(posedge clk); #1;
    wr_now(a, d);
  endtask

  task automatic step_to(int target, int ha, int hb);
    while (cyc < target) begin
      @(posedge clk); #1;
      hold_low = (cyc >= ha && cyc <= hb);
      if (hold_low) chk(scl_o === 1'b1, "R9", "scl_o during stretch", scl_o, 1);
    end
    hold_low = 1'b0;
  endtask

  task automatic run_scn(string t, int p, bit hs, int lo, int hi, int shc, int dv,
                         int nper, int sp, int m, bit srst_end);
    int w, last, ha, hb, per;
    tag = t;
    per = hi + lo + 3 + FILT / 2;
    @(posedge clk); #1;
    w = cyc;
    cfg_we = 1'b1;
    cfg_addr = 2'd0;
    cfg_wdata = ctrl_word(p, hs, 1'b1, 1'b0);
    push_periods(w, p, lo, hi, shc, dv, nper, sp, m, last);
    if (sp >= 0) begin
      ha = w + ((sp * per + 1) << p);
      hb = w + ((sp * per + m) << p);
    end else begin
      ha = -1;
      hb = -2;
    end
    @(posedge clk); #1;
    cfg_we = 1'b0;
    step_to(last, ha, hb);
    if (srst_end) begin
      wr_now(0, ctrl_word(p, hs, 1'b1, 1'b1));
      w = cyc;
      push_periods(w, p, lo, hi, shc, dv, nper, -1, 0, last);
      step_to(last, -1, -2);
    end
    wr_now(0, ctrl_word(p, hs, 1'b0, 1'b0));
    repeat (20) @(posedge clk);
    #1;
    chk(scl_o === 1'b1, "R10", "scl_o after disable", scl_o, 1);
    chk(expq.size() == 0, "R4", "expected strobes still pending", expq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, idle
    repeat (8) begin
      @(posedge clk); #1;
      chk(scl_o === 1'b1, "R1", "scl_o after reset", scl_o, 1);
      chk(!(rise || fall || sh || sda), "R1", "strobes after reset", int'(rise | fall | sh | sda), 0);
    end
    // R2 and R4: junk in unused bits must not alter timing
    wr_reg(1, tword(1, 1, 2, 3, 1'b1));
    run_scn("R2/R4", 0, 1'b0, 3, 2, 1, 1, 2, -1, 0, 1'b0);
    // R3: prescale exponent 2, zero hold and data-valid counts
    wr_reg(1, tword(0, 0, 2, 3, 1'b0));
    run_scn("R3", 2, 1'b0, 3, 2, 0, 0, 2, -1, 0, 1'b0);
    // R8: bank 1, hold coincides with fall, data-valid with rise
    wr_reg(2, tword(5, 3, 1, 5, 1'b0));
    run_scn("R8", 0, 1'b1, 5, 1, 3, 5, 2, -1, 0, 1'b0);
    // R9: slave stretches second high phase by 3 ticks
    wr_reg(1, tword(1, 1, 2, 3, 1'b0));
    run_scn("R9", 0, 1'b0, 3, 2, 1, 1, 3, 1, 3, 1'b0);
    // R11: soft reset at end of a period restarts ticks
    run_scn("R11", 0, 1'b0, 3, 2, 1, 1, 1, -1, 0, 1'b1);
    // R6 and R7: counts beyond their phase never fire
    wr_reg(1, tword(4, 7, 2, 3, 1'b0));
    run_scn("R6/R7", 0, 1'b0, 3, 2, 7, 4, 2, -1, 0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule